// File: doc/BRIEF.md
# Routed Level Interrupt Controller

The block gathers 32 level-sensitive interrupt lines and steers each one to any subset of 4 cores and any subset of 4 interrupt pins. It drives a 4x4 grid of 16 output lines, one per core/pin pair. Software programs it through a simple synchronous register port. Each line has a routing byte: its low nibble picks the cores and its high nibble picks the pins. A set/clear pair of words masks the lines, and one status word per core reports the enabled, active lines routed to that core.

Output `4*c + p` is raised when two things are true at once. Core `c` has a nonzero status word, and some enabled, active line is routed to pin `p`. The two conditions may come from different lines. Each core status word can also be written by software. A written value lasts until a change of line levels, enables or routing causes the word to be recomputed.

Register map (byte offsets):

| Offset | Access | Contents |
|---|---|---|
| 0x00–0x1F | byte only | one routing byte per line |
| 0x20 | word read | status word |
| 0x28 | word write | enable set |
| 0x2C | word write | enable clear |
| 0x40 + 8*n | word read/write | status of core n |

Top module: `irq_router`

## Requirements
- R1: A word read at 0x20 returns the bitwise AND of the current line levels (`irq_i`) and the enable word. Changes on `irq_i` are followed level by level and never latched.
- R2: Line k's routing byte sits at byte address k, for k from 0 to 31. It is reached only with byte accesses (`bus_size_i`=0), and a byte read returns it in bits [7:0] with the upper bits zero. Bits [3:0] select cores 0..3 and bits [7:4] select pins 0..3.
- R3: A word write (`bus_size_i`=1) to 0x28 sets every enable bit written as 1. A word write to 0x2C clears every enable bit written as 1. Bits written as 0 are left unchanged.
- R4: A word read at 0x40+8*n (n=0..3) returns the status of core n. This is the set of enabled, active lines whose routing byte has bit n set.
- R5: Output bit 4*c+p is 1 exactly when the status of core c is nonzero and some enabled, active line has routing bit 4+p set. The two conditions need not come from the same line.
- R6: Outside 0x00–0x1F, an access is ignored if it is a byte access or is not 4-byte aligned. An ignored write changes no register, and an ignored read returns zero. A word access inside 0x00–0x1F is also ignored.
- R7: A word write to 0x40+8*n stores the written value as the status of core n, and that value drives the outputs. It is replaced when the line levels, the enable word or a routing byte next change.
- R8: After reset, all routing bytes, the enable word, every core status and all outputs are zero.
- R9: Outputs are registered. A change on `irq_i` or a register write shows on `irq_o` after exactly one rising clock edge, and with no such change `irq_o` holds.
- R10: A word read of an aligned address that maps to no register (for example 0x30 or 0x44) returns zero. `bus_rdata_o` is loaded on each read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| irq_i | input | 32 | interrupt line levels |
| bus_valid_i | input | 1 | access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 1 | 0 = byte, 1 = word |
| bus_addr_i | input | 8 | byte address |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data, valid the cycle after a read |
| irq_o | output | 16 | core/pin outputs, index 4*core+pin |

## Verification
Every result is due one rising edge after its stimulus. Read data is due one edge after the read request, and `irq_o` is due one edge after a line change or register write. The driver pushes each expected value when it applies the stimulus and raises an issue flag. That flag passes through a one-edge pipe, and the monitor pops and compares on the falling edge that follows, which is exactly when the registered result has settled. The output-latency case changes `irq_i` in the same cycle that it queues the expected value. A design needing a second edge would therefore be caught.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam logic [7:0] ADDR_STATUS    = 8'h20;
  localparam logic [7:0] ADDR_EN_SET    = 8'h28;
  localparam logic [7:0] ADDR_EN_CLR    = 8'h2C;
  localparam logic [7:0] ADDR_CORE_BASE = 8'h40;
  localparam int         CORE_STRIDE_W  = 3;    // 8-byte stride between core status words

  typedef enum logic [1:0] {
    RD_NONE,
    RD_ROUTE,
    RD_STATUS,
    RD_CORE
  } rd_sel_e;
endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
  import irq_router_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  localparam int LINE_W = $clog2(N_LINES),
  localparam int CORE_W = $clog2(N_CORES)
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              route_we_o,
  output logic [LINE_W-1:0] route_idx_o,
  output logic              en_set_o,
  output logic              en_clr_o,
  output logic [N_CORES-1:0] core_we_o,
  output logic [CORE_W-1:0] core_idx_o,
  output rd_sel_e           rd_sel_o
);
  logic              in_route, word_ok, core_hit;
  logic [ADDR_W-1:0] core_off;

  assign in_route    = addr_i < ADDR_W'(N_LINES);
  assign word_ok     = size_i && (addr_i[1:0] == 2'b00) && !in_route;
  assign core_off    = addr_i - ADDR_W'(ADDR_CORE_BASE);
  assign core_hit    = (addr_i >= ADDR_W'(ADDR_CORE_BASE)) && (core_off[CORE_STRIDE_W-1:0] == '0)
                       && (core_off[ADDR_W-1:CORE_STRIDE_W+CORE_W] == '0);
  assign core_idx_o  = core_off[CORE_STRIDE_W +: CORE_W];
  assign route_idx_o = addr_i[LINE_W-1:0];

  assign route_we_o  = valid_i && write_i && !size_i && in_route;
  assign en_set_o    = valid_i && write_i && word_ok && (addr_i == ADDR_W'(ADDR_EN_SET));
  assign en_clr_o    = valid_i && write_i && word_ok && (addr_i == ADDR_W'(ADDR_EN_CLR));

  always_comb begin
    core_we_o = '0;
    if (valid_i && write_i && word_ok && core_hit) core_we_o[core_idx_o] = 1'b1;
  end

  always_comb begin
    rd_sel_o = RD_NONE;
    if (!size_i && in_route)                             rd_sel_o = RD_ROUTE;
    else if (word_ok && addr_i == ADDR_W'(ADDR_STATUS))  rd_sel_o = RD_STATUS;
    else if (word_ok && core_hit)                        rd_sel_o = RD_CORE;
  end
endmodule

// File: rtl/irq_router_route_map.sv
module irq_router_route_map #(
  parameter int N_LINES = 32,
  parameter int N_CORES = 4,
  parameter int N_PINS  = 4,
  localparam int ROUTE_W = N_CORES + N_PINS
) (
  input  logic [N_LINES-1:0][ROUTE_W-1:0] route_i,
  output logic [N_CORES-1:0][N_LINES-1:0] core_mask_o,
  output logic [N_PINS-1:0][N_LINES-1:0]  pin_mask_o
);
  // transpose per-line routing into per-target line masks
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assign core_mask_o[c][l] = route_i[l][c];
    end
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      assign pin_mask_o[p][l] = route_i[l][N_CORES+p];
    end
  end
endmodule

// File: rtl/irq_router_core_stat.sv
module irq_router_core_stat #(
  parameter int N_LINES = 32,
  parameter int N_CORES = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            recompute_i,
  input  logic [N_LINES-1:0]              stat_i,
  input  logic [N_CORES-1:0][N_LINES-1:0] core_mask_i,
  input  logic [N_CORES-1:0]              core_we_i,
  input  logic [N_LINES-1:0]              wdata_i,
  output logic [N_CORES-1:0][N_LINES-1:0] core_d_o,
  output logic [N_CORES-1:0][N_LINES-1:0] core_q_o
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    // recompute beats a same-cycle software write
    assign core_d_o[c] = recompute_i  ? (stat_i & core_mask_i[c]) :
                         core_we_i[c] ? wdata_i : core_q_o[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) core_q_o[c] <= '0;
      else         core_q_o[c] <= core_d_o[c];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int N_CORES = 4,
  parameter int N_PINS  = 4,
  parameter int ADDR_W  = 8,
  localparam int ROUTE_W = N_CORES + N_PINS,
  localparam int N_OUT   = N_CORES * N_PINS,
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int CORE_W  = $clog2(N_CORES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic               bus_size_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [N_LINES-1:0] bus_wdata_i,
  output logic [N_LINES-1:0] bus_rdata_o,
  output logic [N_OUT-1:0]   irq_o
);
  logic                            route_we, en_set, en_clr, recompute;
  logic [LINE_W-1:0]               route_idx;
  logic [CORE_W-1:0]               core_idx;
  logic [N_CORES-1:0]              core_we;
  rd_sel_e                         rd_sel;
  logic [N_LINES-1:0][ROUTE_W-1:0] route_q, route_d;
  logic [N_LINES-1:0]              en_q, en_d, act_q, stat_d, rd_d;
  logic [N_CORES-1:0][N_LINES-1:0] core_mask, core_d, core_q;
  logic [N_PINS-1:0][N_LINES-1:0]  pin_mask;
  logic [N_PINS-1:0]               pin_any_d;
  logic [N_OUT-1:0]                irq_d;

  irq_router_decode #(.N_LINES(N_LINES), .N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_decode (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .size_i(bus_size_i), .addr_i(bus_addr_i),
    .route_we_o(route_we), .route_idx_o(route_idx), .en_set_o(en_set), .en_clr_o(en_clr),
    .core_we_o(core_we), .core_idx_o(core_idx), .rd_sel_o(rd_sel)
  );

  always_comb begin
    route_d = route_q;
    if (route_we) route_d[route_idx] = bus_wdata_i[ROUTE_W-1:0];
  end

  assign en_d      = (en_q | (en_set ? bus_wdata_i : '0)) & ~(en_clr ? bus_wdata_i : '0);
  assign stat_d    = irq_i & en_d;
  assign recompute = (irq_i != act_q) || (en_d != en_q) || route_we;

  irq_router_route_map #(.N_LINES(N_LINES), .N_CORES(N_CORES), .N_PINS(N_PINS)) u_map (
    .route_i(route_d), .core_mask_o(core_mask), .pin_mask_o(pin_mask)
  );

  irq_router_core_stat #(.N_LINES(N_LINES), .N_CORES(N_CORES)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .recompute_i(recompute), .stat_i(stat_d),
    .core_mask_i(core_mask), .core_we_i(core_we), .wdata_i(bus_wdata_i),
    .core_d_o(core_d), .core_q_o(core_q)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign pin_any_d[p] = |(stat_d & pin_mask[p]);
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assign irq_d[c*N_PINS+p] = (|core_d[c]) && pin_any_d[p];
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (rd_sel)
      RD_ROUTE:  rd_d = {{(N_LINES-ROUTE_W){1'b0}}, route_q[route_idx]};
      RD_STATUS: rd_d = act_q & en_q;
      RD_CORE:   rd_d = core_q[core_idx];
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q     <= '0;
      en_q        <= '0;
      act_q       <= '0;
      irq_o       <= '0;
      bus_rdata_o <= '0;
    end else begin
      route_q <= route_d;
      en_q    <= en_d;
      act_q   <= irq_i;
      irq_o   <= irq_d;
      if (bus_valid_i && !bus_write_i) bus_rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_LINES = 32,
  parameter int N_CORES = 4,
  parameter int N_PINS  = 4,
  parameter int ADDR_W  = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [N_LINES-1:0]              irq_i,
  input logic                            bus_valid_i,
  input logic                            bus_write_i,
  input logic                            bus_size_i,
  input logic [ADDR_W-1:0]               bus_addr_i,
  input logic [N_LINES-1:0]              bus_rdata_o,
  input logic [N_CORES*N_PINS-1:0]       irq_o,
  input logic [N_LINES-1:0]              act_q,
  input logic [N_CORES-1:0][N_LINES-1:0] core_q
);
  p_reset_idle_r8: assert property (@(posedge clk_i) !rst_ni |-> irq_o == '0);

  p_quiet_lines_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == '0 |=> irq_o == '0);

  p_odd_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && bus_size_i && bus_addr_i[1:0] != 2'b00) |=> bus_rdata_o == '0);

  p_byte_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && !bus_size_i && bus_addr_i >= ADDR_W'(N_LINES)) |=> bus_rdata_o == '0);

  p_hold_outputs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == act_q && !(bus_valid_i && bus_write_i)) |=> $stable(irq_o));

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      p_core_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[c*N_PINS+p] |-> (core_q[c] != '0));
    end
  end
endmodule

bind irq_router irq_router_chk #(
  .N_LINES(N_LINES), .N_CORES(N_CORES), .N_PINS(N_PINS), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i), .bus_size_i(bus_size_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .act_q(act_q), .core_q(core_q)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0, bus_size_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [15:0] irq_o;

  irq_router u_irq_router (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .bus_valid_i(bus_valid_i),
    .bus_write_i(bus_write_i), .bus_size_i(bus_size_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {logic [31:0] exp; string tag;} item_t;
  item_t rd_q[$];
  item_t irq_q[$];
  logic  rd_issue = 1'b0, irq_issue = 1'b0, rd_pipe = 1'b0, irq_pipe = 1'b0;
  int    checks = 0, errors = 0;

  always @(posedge clk_i) begin
    rd_pipe  <= rd_issue;
    irq_pipe <= irq_issue;
  end

  // monitor: results are due one edge after issue
  always @(negedge clk_i) begin
    item_t it;
    if (rd_pipe && rd_q.size() > 0) begin
      it = rd_q.pop_front();
      checks++;
      if (bus_rdata_o !== it.exp) begin
        errors++;
        $display("FAIL %s rdata=%h expected=%h", it.tag, bus_rdata_o, it.exp);
      end
    end
    if (irq_pipe && irq_q.size() > 0) begin
      it = irq_q.pop_front();
      checks++;
      if (irq_o !== it.exp[15:0]) begin
        errors++;
        $display("FAIL %s irq_o=%h expected=%h", it.tag, irq_o, it.exp[15:0]);
      end
    end
  end

  task automatic wr(logic sz, logic [7:0] a, logic [31:0] d);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_size_i = sz; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
  endtask

  task automatic rd(logic sz, logic [7:0] a, logic [31:0] exp, string tag);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_size_i = sz; bus_addr_i = a;
    rd_issue = 1'b1;
    rd_q.push_back('{exp, tag});
    @(negedge clk_i);
    bus_valid_i = 1'b0; rd_issue = 1'b0;
  endtask

  task automatic chk_irq(logic [15:0] exp, string tag);
    irq_issue = 1'b1;
    irq_q.push_back('{{16'h0, exp}, tag});
    @(negedge clk_i);
    irq_issue = 1'b0;
  endtask

  task automatic lines(logic [31:0] v);
    irq_i = v;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8 reset state
    chk_irq(16'h0000, "R8 outputs after reset");
    rd(1'b1, 8'h20, 32'h0, "R8 status after reset");
    rd(1'b0, 8'h05, 32'h0, "R8 route byte after reset");
    rd(1'b1, 8'h40, 32'h0, "R8 core0 after reset");
    // R2 routing
    wr(1'b0, 8'h03, 32'h21);
    wr(1'b0, 8'h07, 32'h82);
    wr(1'b0, 8'h0A, 32'h14);
    wr(1'b0, 8'h05, 32'hF8);
    rd(1'b0, 8'h03, 32'h21, "R2 route byte 3");
    rd(1'b0, 8'h07, 32'h82, "R2 route byte 7");
    // R3 enable lines 3,7,10
    wr(1'b1, 8'h28, 32'h0000_0488);
    // R9 latency: change line and expect after one edge
    irq_i = 32'h8;
    chk_irq(16'h0002, "R9 one-edge latency line3");
    rd(1'b1, 8'h20, 32'h8, "R1 status line3");
    rd(1'b1, 8'h40, 32'h8, "R4 core0 status");
    rd(1'b1, 8'h48, 32'h0, "R4 core1 status");
    lines(32'h408);
    chk_irq(16'h0303, "R5 cross core/pin");
    rd(1'b1, 8'h50, 32'h400, "R4 core2 status");
    // R1 masking: line5 active, disabled
    lines(32'h428);
    rd(1'b1, 8'h20, 32'h408, "R1 disabled line masked");
    rd(1'b1, 8'h58, 32'h0, "R4 core3 masked");
    chk_irq(16'h0303, "R5 disabled line no effect");
    wr(1'b1, 8'h28, 32'h20);
    rd(1'b1, 8'h20, 32'h428, "R3 enable set line5");
    rd(1'b1, 8'h58, 32'h20, "R4 core3 after enable");
    chk_irq(16'hFF0F, "R5 all pins active");
    wr(1'b1, 8'h2C, 32'h20);
    rd(1'b1, 8'h58, 32'h0, "R3 enable clear line5");
    chk_irq(16'h0303, "R3 outputs after clear");
    // R6 ignored accesses
    wr(1'b1, 8'h29, 32'hFFFF_FFFF);
    wr(1'b0, 8'h28, 32'hFF);
    wr(1'b1, 8'h04, 32'hFFFF_FFFF);
    rd(1'b1, 8'h20, 32'h408, "R6 enable untouched");
    rd(1'b0, 8'h04, 32'h0, "R6 route byte 4 untouched");
    rd(1'b0, 8'h07, 32'h82, "R6 route byte 7 untouched");
    rd(1'b1, 8'h22, 32'h0, "R6 misaligned read zero");
    rd(1'b0, 8'h20, 32'h0, "R6 byte read outside routing");
    rd(1'b1, 8'h00, 32'h0, "R6 word read in routing region");
    chk_irq(16'h0303, "R6 outputs untouched");
    // R10 unmapped
    rd(1'b1, 8'h30, 32'h0, "R10 unmapped 0x30");
    rd(1'b1, 8'h44, 32'h0, "R10 unmapped 0x44");
    // R7 software core status write
    wr(1'b1, 8'h48, 32'h80);
    rd(1'b1, 8'h48, 32'h80, "R7 core1 written value");
    chk_irq(16'h0333, "R7 written core drives outputs");
    lines(32'h429);
    rd(1'b1, 8'h48, 32'h0, "R7 core1 recomputed");
    chk_irq(16'h0303, "R7 outputs after recompute");
    rd(1'b1, 8'h40, 32'h8, "R7 core0 recomputed");
    // R9 hold then drop
    chk_irq(16'h0303, "R9 hold without change");
    irq_i = 32'h0;
    chk_irq(16'h0000, "R9 drop after one edge");
    repeat (3) @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule